// File: doc/BRIEF.md
# Saved Context Readout Interlock

This block keeps the 128-bit result context that a cipher core produces at the end of an operation. Depending on the mode, that context is the final chaining value, the final counter, or the authentication tag. When the core finishes an operation with context saving enabled, it pulses a capture strobe and presents the context. The block latches it, raises a ready flag and drops a start-permit output. The core must not begin a new operation while that permit is low. The host reads the context through a small read port as four 32-bit words. Reading the last word releases the core again, so the core stays held until software has taken the whole context.

The context can be read through two equal views. The chaining-value view sits at addresses 0 to 3 and the tag view sits at addresses 4 to 7. Both views return the same latched data, and the last word of either view releases the core. A status word at address 8 shows the ready and pending flags.

A capture that arrives while the flag is still set does not overwrite the visible context. It is parked in a pending buffer and promoted when the host releases the current context.

The control is a three-state machine:
- `ST_EMPTY`: no context is held and the permit is high.
- `ST_FULL`: a context is held and the permit is low.
- `ST_FULL_PEND`: a context is held and a second one is parked.

The transitions are:
- `EMPTY->FULL`: on a capture.
- `FULL->EMPTY`: on a last-word read.
- `FULL->FULL`: on a last-word read together with a capture; the new context is latched.
- `FULL->FULL_PEND`: on a capture without a last-word read.
- `FULL_PEND->FULL`: on a last-word read; the parked context is promoted.
- Any other input combination leaves the state unchanged.

Top module: `ctx_readout_lock`

## Requirements
- R1: After reset, start_ok is 1, the status word reads 0, and every readable address returns 0.
- R2: A capture strobe in the empty state latches cap_data and sets the ready flag. From the next cycle start_ok is 0.
- R3: Word k of the context is cap_data bits [32k+31:32k]. It is readable at address k (chaining-value view) and at address 4+k (tag view), k = 0..3.
- R4: Reads of addresses 0, 1, 2, 4, 5 and 6 return the latched data and leave the ready flag and start_ok unchanged.
- R5: A read of address 3 or 7 while ready is set and nothing is pending clears the ready flag. From the next cycle start_ok is 1.
- R6: A capture while ready is set parks the new data as pending and sets status bit 1. Reads keep returning the old context.
- R7: A last-word read while a context is pending replaces the visible context with the pending one. Ready stays set, pending clears, and start_ok stays 0.
- R8: A capture arriving while a context is already pending is discarded.
- R9: A capture in the same cycle as a last-word read in the ready state (with nothing pending) latches the new context and keeps ready set. The read itself returns the old word.
- R10: Reads while the ready flag is clear return the last latched context and have no effect.
- R11: Address 8 returns the status word with bit 0 = ready and bit 1 = pending, all other bits 0. Addresses 9 to 15 return 0. Neither kind of read changes any state.
- R12: rd_data updates on the clock edge that samples rd_en = 1 and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_stb | input | 1 | One-cycle capture strobe from the core |
| cap_data | input | 128 | Context presented with the strobe |
| start_ok | output | 1 | High when the core may begin a new operation |
| rd_en | input | 1 | Host read request |
| rd_addr | input | 4 | Host word address |
| rd_data | output | 32 | Registered read data |

## Verification
The embedded properties watch every cycle for the following:
- A capture always drops the start permit.
- Low-word reads never release the core.
- A last-word read with nothing pending always releases it.
- A pending promotion keeps the core held.
- The visible context never moves while the core is held and no last-word read occurs.
- Read data holds between reads.

Only the bench scenarios can show the data itself. These cover which bits land in which word under both views, that parked data is the data later promoted, that a third capture is discarded, and what a coincident capture and release returns.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY     = 2'd0,
        ST_FULL      = 2'd1,
        ST_FULL_PEND = 2'd2
    } ctx_state_e;

    // Number of read views that alias the same context
    localparam int unsigned NUM_VIEWS = 2;

endpackage

// File: rtl/ctx_lock_fsm.sv
module ctx_lock_fsm
    import ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_stb,
    input  logic last_rd,
    output logic ld_cap,
    output logic ld_pend,
    output logic ld_promote,
    output logic ready,
    output logic pending,
    output logic start_ok
);

    ctx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        ld_cap     = 1'b0;
        ld_pend    = 1'b0;
        ld_promote = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (cap_stb) begin
                    ld_cap  = 1'b1;
                    state_d = ST_FULL;
                end
            end
            ST_FULL: begin
                if (cap_stb && last_rd) begin
                    ld_cap  = 1'b1;
                    state_d = ST_FULL;
                end else if (last_rd) begin
                    state_d = ST_EMPTY;
                end else if (cap_stb) begin
                    ld_pend = 1'b1;
                    state_d = ST_FULL_PEND;
                end
            end
            ST_FULL_PEND: begin
                if (last_rd) begin
                    ld_promote = 1'b1;
                    state_d    = ST_FULL;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        ready    = (state_q != ST_EMPTY);
        pending  = (state_q == ST_FULL_PEND);
        start_ok = (state_q == ST_EMPTY);
    end

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> !start_ok); // R2
    AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !pending && last_rd && !cap_stb) |=> start_ok); // R5
    AST_PROMOTE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && last_rd) |=> (!start_ok && !pending)); // R7

endmodule

// File: rtl/ctx_store.sv
module ctx_store #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    localparam int unsigned CTX_W    = WORD_W * NUM_WORDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_cap,
    input  logic             ld_pend,
    input  logic             ld_promote,
    input  logic [CTX_W-1:0] cap_data,
    output logic [CTX_W-1:0] ctx_q
);

    logic [CTX_W-1:0] pend_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctx_q[g*WORD_W +: WORD_W]  <= '0;
                pend_q[g*WORD_W +: WORD_W] <= '0;
            end else begin
                if (ld_cap)
                    ctx_q[g*WORD_W +: WORD_W] <= cap_data[g*WORD_W +: WORD_W];
                else if (ld_promote)
                    ctx_q[g*WORD_W +: WORD_W] <= pend_q[g*WORD_W +: WORD_W];
                if (ld_pend)
                    pend_q[g*WORD_W +: WORD_W] <= cap_data[g*WORD_W +: WORD_W];
            end
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_cap && ld_promote)); // R7

endmodule

// File: rtl/ctx_rdport.sv
module ctx_rdport
    import ctx_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned ADDR_W    = 4,
    localparam int unsigned CTX_W    = WORD_W * NUM_WORDS,
    localparam int unsigned IDX_W    = $clog2(NUM_WORDS),
    localparam int unsigned VIEW_W   = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CTX_W-1:0]  ctx,
    input  logic              ready,
    input  logic              pending,
    output logic              last_rd,
    output logic [WORD_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(NUM_VIEWS * NUM_WORDS);
    localparam logic [IDX_W-1:0]  LAST_IDX    = IDX_W'(NUM_WORDS - 1);
    localparam logic [VIEW_W-1:0] VIEW_LIMIT  = VIEW_W'(NUM_VIEWS);

    logic [WORD_W-1:0] words [NUM_WORDS];
    logic [IDX_W-1:0]  idx;
    logic [VIEW_W-1:0] view;
    logic              in_ctx;
    logic [WORD_W-1:0] rd_next;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_split
        assign words[g] = ctx[g*WORD_W +: WORD_W];
    end

    always_comb begin
        idx     = rd_addr[IDX_W-1:0];
        view    = rd_addr[ADDR_W-1:IDX_W];
        in_ctx  = (view < VIEW_LIMIT);
        last_rd = rd_en && in_ctx && (idx == LAST_IDX);
        if (in_ctx)
            rd_next = words[idx];
        else if (rd_addr == STATUS_ADDR)
            rd_next = {{(WORD_W-2){1'b0}}, pending, ready};
        else
            rd_next = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R12
    AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == STATUS_ADDR) |=> (rd_data[WORD_W-1:2] == '0)); // R11

endmodule

// File: rtl/ctx_readout_lock.sv
module ctx_readout_lock #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned ADDR_W    = 4,
    localparam int unsigned CTX_W    = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stb,
    input  logic [CTX_W-1:0]  cap_data,
    output logic              start_ok,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic             ld_cap, ld_pend, ld_promote;
    logic             ready, pending, last_rd;
    logic [CTX_W-1:0] ctx_q;

    ctx_lock_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_stb    (cap_stb),
        .last_rd    (last_rd),
        .ld_cap     (ld_cap),
        .ld_pend    (ld_pend),
        .ld_promote (ld_promote),
        .ready      (ready),
        .pending    (pending),
        .start_ok   (start_ok)
    );

    ctx_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_cap     (ld_cap),
        .ld_pend    (ld_pend),
        .ld_promote (ld_promote),
        .cap_data   (cap_data),
        .ctx_q      (ctx_q)
    );

    ctx_rdport #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .ctx     (ctx_q),
        .ready   (ready),
        .pending (pending),
        .last_rd (last_rd),
        .rd_data (rd_data)
    );

    AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ok && !last_rd) |=> $stable(ctx_q)); // R6
    AST_LOW_WORD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ok && !last_rd) |=> !start_ok); // R4

endmodule

// File: tb/ctx_readout_lock_tb.sv
module ctx_readout_lock_tb;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_stb = 1'b0;
    logic [127:0] cap_data = '0;
    logic         start_ok;
    logic         rd_en = 1'b0;
    logic [3:0]   rd_addr = '0;
    logic [31:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [127:0] m_ctx = '0, m_pdata = '0;
    logic         m_ready = 1'b0, m_pend = 1'b0;
    logic [31:0]  m_rdata = '0;

    always #(CLK_P/2) clk = ~clk;

    ctx_readout_lock u_dut (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .cap_data(cap_data),
        .start_ok(start_ok), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [127:0] pat(input int n);
        logic [127:0] v;
        for (int k = 0; k < 4; k++)
            v[k*32 +: 32] = 32'hA5000000 + 32'(n) * 32'h10101 + 32'(k) * 32'h11;
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        if (a < 4'd8)       return m_ctx[a[1:0]*32 +: 32];
        else if (a == 4'd8) return {30'd0, m_pend, m_ready};
        else                return 32'd0;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic op(input string req, input logic cap, input logic [127:0] d,
                      input logic rd, input logic [3:0] a);
        logic last;
        @(negedge clk);
        cap_stb = cap; cap_data = d; rd_en = rd; rd_addr = a;
        if (rd) m_rdata = model_read(a);
        last = rd && (a < 4'd8) && (a[1:0] == 2'd3);
        if (!m_ready) begin
            if (cap) begin m_ctx = d; m_ready = 1'b1; end
        end else if (!m_pend) begin
            if (cap && last) m_ctx = d;
            else if (last) m_ready = 1'b0;
            else if (cap) begin m_pend = 1'b1; m_pdata = d; end
        end else if (last) begin
            m_ctx = m_pdata; m_pend = 1'b0;
        end
        @(negedge clk);
        cap_stb = 1'b0; rd_en = 1'b0;
        check(req, "rd_data", rd_data, m_rdata);
        check(req, "start_ok", {31'd0, start_ok}, {31'd0, !m_ready});
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, every address reads zero
        check("R1", "start_ok after reset", {31'd0, start_ok}, 32'd1);
        for (int a = 0; a < 16; a++) op("R1", 1'b0, '0, 1'b1, 4'(a));

        // R2 R3 R4 R5 R10 R11: sweep over patterns and all addresses
        for (int n = 0; n < 4; n++) begin
            op("R2", 1'b1, pat(n), 1'b0, '0);
            for (int a = 0; a < 16; a++)
                if (a != 3 && a != 7)
                    op((a < 8) ? "R3_R4" : "R11", 1'b0, '0, 1'b1, 4'(a));
            op("R5", 1'b0, '0, 1'b1, (n % 2 == 0) ? 4'd3 : 4'd7);
            op("R12", 1'b0, '0, 1'b0, '0);
            for (int a = 0; a < 9; a++) op("R10", 1'b0, '0, 1'b1, 4'(a));
        end

        // R6 R7 R8: parked capture, dropped third capture, promotion
        op("R2", 1'b1, pat(10), 1'b0, '0);
        op("R6", 1'b1, pat(11), 1'b0, '0);
        for (int a = 0; a < 3; a++) op("R6", 1'b0, '0, 1'b1, 4'(a));
        op("R6", 1'b0, '0, 1'b1, 4'd8);
        op("R8", 1'b1, pat(12), 1'b0, '0);
        op("R7", 1'b0, '0, 1'b1, 4'd7);
        for (int a = 0; a < 9; a++) op("R7_R8", 1'b0, '0, 1'b1, 4'(a));
        op("R5", 1'b0, '0, 1'b1, 4'd3);

        // R9: capture coincident with last-word read
        op("R2", 1'b1, pat(20), 1'b0, '0);
        op("R9", 1'b1, pat(21), 1'b1, 4'd3);
        for (int a = 0; a < 9; a++) op("R9", 1'b0, '0, 1'b1, 4'(a));
        op("R5", 1'b0, '0, 1'b1, 4'd7);
        op("R12", 1'b0, '0, 1'b0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule